// File: doc/BRIEF.md
# Command mailbox with keyed access

This block is a small register file on a host register bus. A host uses it to pass numbered commands, with two 32-bit operands, to an on-board controller, and then collects a pass/fail flag and two result words. A status word shows whether a command is still running, whether the last one failed, and whether the controller has raised an interrupt.

Every register except the key register is hidden until the host writes a two-word magic sequence to the key register. A single all-ones key write hides them again. The `unlocked` output follows this state, so other special address windows can be enabled or disabled together with the mailbox.

On the controller side, the block gives a one-cycle command strobe that carries the ID and both operands. It takes a completion pulse with an error flag and two result words, and an interrupt request input.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset the block is locked (`unlocked` = 0), `cmd_valid` is low, and busy, error, interrupt-pending, command ID and both data words are zero.
- R2: Two consecutive key-register writes (word address 4), 0x5F554E4C followed directly by 0x4F434B5F, unlock the block from the next cycle on.
- R3: Any other key value resets the sequence, including 0x00000000 and a repeated first word that is not followed directly by the second. Writes to other addresses between two key writes do not break the sequence.
- R4: A key write of 0xFFFFFFFF while unlocked locks the block from the next cycle on. No other write locks it.
- R5: While locked, every read returns zero, and host writes to addresses 0 to 3 change no state.
- R6: An unlocked write to the status word (address 0) sets busy, clears error and stores bits [7:0] as the command ID. On the next cycle `cmd_valid` is high for one cycle, with `cmd_id` and the two current data words on `cmd_arg0`/`cmd_arg1`.
- R7: A `ctl_done` pulse clears busy, loads error from `ctl_err`, and loads DATA0/DATA1 (addresses 1 and 2) from the result inputs, all in the same cycle. A status write in the same cycle keeps busy set and error clear.
- R8: The status word reads with busy in bit 31, error in bit 30, interrupt pending in bit 29, zeros in bits [28:8] and the command ID in bits [7:0]. DATA0/DATA1 read back what the host or the last completion wrote.
- R9: Address 3 reads as 0x53437632 while unlocked.
- R10: `ctl_irq` sets interrupt pending. Any unlocked write to address 3 clears it. If both happen in the same cycle, the bit is set.
- R11: The key register and the unused word addresses 5 to 7 always read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset (power-on or console reset) |
| host_wr | input | 1 | Host write strobe, one word per cycle |
| host_addr | input | 3 | Host word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for `host_addr` (combinational) |
| cmd_valid | output | 1 | One-cycle command strobe to the controller |
| cmd_id | output | 8 | Dispatched command ID |
| cmd_arg0 | output | 32 | Operand word 0 |
| cmd_arg1 | output | 32 | Operand word 1 |
| ctl_done | input | 1 | Controller completion pulse |
| ctl_err | input | 1 | Completion error flag |
| ctl_data0 | input | 32 | Result word 0, or the error code |
| ctl_data1 | input | 32 | Result word 1 |
| ctl_irq | input | 1 | Controller interrupt request |
| unlocked | output | 1 | Keyed access is open |

## Verification
The bench attacks the following weak points of the design:

- **Broken key sequence.** It puts a zero, a stray value and a repeated first word between the two magic words. A sequencer that remembered a half sequence across a bad write would unlock too early.
- **Writes while locked.** It writes data and status while locked. A design that only masked reads would leak those values once unlocked, or dispatch a command.
- **Same-cycle collisions.** It raises an interrupt request in the same cycle as an identifier write, and a completion in the same cycle as a command write. A wrong priority shows up as a lost interrupt or a busy bit dropped for a fresh command.
- **Bit placement and masking.** Random traffic compared against a bench model catches misplaced status bits and upper written bits leaking into the status word.

// File: rtl/cmd_mailbox_pkg.sv
package cmd_mailbox_pkg;

    localparam int MBOX_ADDR_W = 3;

    typedef enum logic [MBOX_ADDR_W-1:0] {
        MB_STATUS = 3'd0,
        MB_DATA0  = 3'd1,
        MB_DATA1  = 3'd2,
        MB_IDENT  = 3'd3,
        MB_KEY    = 3'd4
    } mbox_addr_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_HALF = 1'b1
    } key_seq_e;

endpackage

// File: rtl/mbox_key_seq.sv
module mbox_key_seq #(
    parameter int          DATA_W    = 32,
    parameter logic [31:0] KEY_OPEN1 = 32'h5F554E4C,
    parameter logic [31:0] KEY_OPEN2 = 32'h4F434B5F,
    parameter logic [31:0] KEY_CLOSE = 32'hFFFFFFFF,
    parameter logic [31:0] KEY_RESET = 32'h00000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_data,
    output logic              open_o
);
    import cmd_mailbox_pkg::*;

    typedef struct packed {
        key_seq_e seq;
        logic     open;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (key_wr) begin
            if (key_data == DATA_W'(KEY_RESET)) begin
                st_d.seq = SEQ_IDLE;
            end else if (key_data == DATA_W'(KEY_OPEN1)) begin
                st_d.seq = SEQ_HALF;
            end else begin
                // second word completes only a half sequence; all else drops back
                if (st_q.seq == SEQ_HALF && key_data == DATA_W'(KEY_OPEN2) && !st_q.open) begin
                    st_d.open = 1'b1;
                end
                if (key_data == DATA_W'(KEY_CLOSE) && st_q.open) begin
                    st_d.open = 1'b0;
                end
                st_d.seq = SEQ_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{seq: SEQ_IDLE, open: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign open_o = st_q.open;

endmodule

// File: rtl/mbox_core.sv
module mbox_core #(
    parameter int DATA_W = 32,
    parameter int ID_W   = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                open_i,
    input  logic                                wr_i,
    input  logic [cmd_mailbox_pkg::MBOX_ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0]                   wdata_i,
    input  logic                                done_i,
    input  logic                                done_err_i,
    input  logic [DATA_W-1:0]                   done_d0_i,
    input  logic [DATA_W-1:0]                   done_d1_i,
    input  logic                                irq_i,
    output logic                                busy_o,
    output logic                                err_o,
    output logic                                irq_pend_o,
    output logic [ID_W-1:0]                     id_o,
    output logic [DATA_W-1:0]                   d0_o,
    output logic [DATA_W-1:0]                   d1_o,
    output logic                                strobe_o
);
    import cmd_mailbox_pkg::*;

    typedef struct packed {
        logic              busy;
        logic              err;
        logic              irq;
        logic [ID_W-1:0]   id;
        logic [DATA_W-1:0] d0;
        logic [DATA_W-1:0] d1;
        logic              strobe;
    } core_state_t;

    core_state_t cs_d, cs_q;
    logic        wr_ok;
    logic        new_cmd;

    assign wr_ok   = wr_i && open_i;
    assign new_cmd = wr_ok && (addr_i == MB_STATUS);

    always_comb begin
        cs_d        = cs_q;
        cs_d.strobe = 1'b0;
        if (wr_ok) begin
            unique case (addr_i)
                MB_STATUS: begin
                    cs_d.busy   = 1'b1;
                    cs_d.err    = 1'b0;
                    cs_d.id     = wdata_i[ID_W-1:0];
                    cs_d.strobe = 1'b1;
                end
                MB_DATA0: cs_d.d0  = wdata_i;
                MB_DATA1: cs_d.d1  = wdata_i;
                MB_IDENT: cs_d.irq = 1'b0;
                default: ;
            endcase
        end
        if (done_i) begin
            cs_d.d0 = done_d0_i;
            cs_d.d1 = done_d1_i;
            if (!new_cmd) begin
                cs_d.busy = 1'b0;
                cs_d.err  = done_err_i;
            end
        end
        if (irq_i) begin
            cs_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q <= '0;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign busy_o     = cs_q.busy;
    assign err_o      = cs_q.err;
    assign irq_pend_o = cs_q.irq;
    assign id_o       = cs_q.id;
    assign d0_o       = cs_q.d0;
    assign d1_o       = cs_q.d1;
    assign strobe_o   = cs_q.strobe;

endmodule

// File: rtl/mbox_rmux.sv
module mbox_rmux #(
    parameter int          DATA_W    = 32,
    parameter int          ID_W      = 8,
    parameter logic [31:0] IDENT_VAL = 32'h53437632
) (
    input  logic                                open_i,
    input  logic [cmd_mailbox_pkg::MBOX_ADDR_W-1:0] addr_i,
    input  logic                                busy_i,
    input  logic                                err_i,
    input  logic                                irq_i,
    input  logic [ID_W-1:0]                     id_i,
    input  logic [DATA_W-1:0]                   d0_i,
    input  logic [DATA_W-1:0]                   d1_i,
    output logic [DATA_W-1:0]                   rdata_o
);
    import cmd_mailbox_pkg::*;

    localparam int PAD_W = DATA_W - 3 - ID_W;

    logic [DATA_W-1:0] status_w;
    assign status_w = {busy_i, err_i, irq_i, {PAD_W{1'b0}}, id_i};

    always_comb begin
        rdata_o = '0;
        if (open_i) begin
            unique case (addr_i)
                MB_STATUS: rdata_o = status_w;
                MB_DATA0:  rdata_o = d0_i;
                MB_DATA1:  rdata_o = d1_i;
                MB_IDENT:  rdata_o = DATA_W'(IDENT_VAL);
                default:   rdata_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox #(
    parameter int          DATA_W    = 32,
    parameter int          ID_W      = 8,
    parameter logic [31:0] IDENT_VAL = 32'h53437632,
    parameter logic [31:0] KEY_OPEN1 = 32'h5F554E4C,
    parameter logic [31:0] KEY_OPEN2 = 32'h4F434B5F,
    parameter logic [31:0] KEY_CLOSE = 32'hFFFFFFFF,
    parameter logic [31:0] KEY_RESET = 32'h00000000
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                host_wr,
    input  logic [cmd_mailbox_pkg::MBOX_ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0]                   host_wdata,
    output logic [DATA_W-1:0]                   host_rdata,
    output logic                                cmd_valid,
    output logic [ID_W-1:0]                     cmd_id,
    output logic [DATA_W-1:0]                   cmd_arg0,
    output logic [DATA_W-1:0]                   cmd_arg1,
    input  logic                                ctl_done,
    input  logic                                ctl_err,
    input  logic [DATA_W-1:0]                   ctl_data0,
    input  logic [DATA_W-1:0]                   ctl_data1,
    input  logic                                ctl_irq,
    output logic                                unlocked
);
    import cmd_mailbox_pkg::*;

    logic              key_wr;
    logic              st_busy;
    logic              st_err;
    logic              st_irq;
    logic [ID_W-1:0]   st_id;
    logic [DATA_W-1:0] st_d0;
    logic [DATA_W-1:0] st_d1;

    assign key_wr = host_wr && (host_addr == MB_KEY);

    mbox_key_seq #(
        .DATA_W(DATA_W), .KEY_OPEN1(KEY_OPEN1), .KEY_OPEN2(KEY_OPEN2),
        .KEY_CLOSE(KEY_CLOSE), .KEY_RESET(KEY_RESET)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_data(host_wdata),
        .open_o(unlocked)
    );

    mbox_core #(.DATA_W(DATA_W), .ID_W(ID_W)) u_core (
        .clk(clk), .rst_n(rst_n), .open_i(unlocked),
        .wr_i(host_wr), .addr_i(host_addr), .wdata_i(host_wdata),
        .done_i(ctl_done), .done_err_i(ctl_err),
        .done_d0_i(ctl_data0), .done_d1_i(ctl_data1), .irq_i(ctl_irq),
        .busy_o(st_busy), .err_o(st_err), .irq_pend_o(st_irq),
        .id_o(st_id), .d0_o(st_d0), .d1_o(st_d1), .strobe_o(cmd_valid)
    );

    mbox_rmux #(.DATA_W(DATA_W), .ID_W(ID_W), .IDENT_VAL(IDENT_VAL)) u_rmux (
        .open_i(unlocked), .addr_i(host_addr),
        .busy_i(st_busy), .err_i(st_err), .irq_i(st_irq), .id_i(st_id),
        .d0_i(st_d0), .d1_i(st_d1), .rdata_o(host_rdata)
    );

    assign cmd_id   = st_id;
    assign cmd_arg0 = st_d0;
    assign cmd_arg1 = st_d1;

endmodule

// File: rtl/cmd_mailbox_checker.sv
module cmd_mailbox_checker #(
    parameter int          DATA_W    = 32,
    parameter int          ID_W      = 8,
    parameter logic [31:0] IDENT_VAL = 32'h53437632,
    parameter logic [31:0] KEY_OPEN2 = 32'h4F434B5F,
    parameter logic [31:0] KEY_CLOSE = 32'hFFFFFFFF
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                host_wr,
    input logic [cmd_mailbox_pkg::MBOX_ADDR_W-1:0] host_addr,
    input logic [DATA_W-1:0]                   host_wdata,
    input logic [DATA_W-1:0]                   host_rdata,
    input logic                                cmd_valid,
    input logic [ID_W-1:0]                     cmd_id,
    input logic                                ctl_done,
    input logic                                ctl_irq,
    input logic                                unlocked,
    input logic                                st_busy,
    input logic                                st_irq
);
    import cmd_mailbox_pkg::*;

    logic key_w, stat_w;
    assign key_w  = host_wr && (host_addr == MB_KEY);
    assign stat_w = host_wr && unlocked && (host_addr == MB_STATUS);

    assert_unlock_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(key_w && host_wdata == DATA_W'(KEY_OPEN2)));

    assert_lock_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(unlocked) |-> $past(key_w && host_wdata == DATA_W'(KEY_CLOSE)));

    assert_locked_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |-> host_rdata == '0);

    assert_cmd_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_w |=> cmd_valid && cmd_id == $past(host_wdata[ID_W-1:0]));

    assert_done_clears_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_done && !stat_w |=> !st_busy);

    assert_ident_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
        unlocked && host_addr == MB_IDENT |-> host_rdata == DATA_W'(IDENT_VAL));

    assert_irq_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_irq |=> st_irq);

endmodule

bind cmd_mailbox cmd_mailbox_checker #(
    .DATA_W(DATA_W), .ID_W(ID_W), .IDENT_VAL(IDENT_VAL),
    .KEY_OPEN2(KEY_OPEN2), .KEY_CLOSE(KEY_CLOSE)
) u_checker (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .cmd_valid(cmd_valid),
    .cmd_id(cmd_id), .ctl_done(ctl_done), .ctl_irq(ctl_irq),
    .unlocked(unlocked), .st_busy(st_busy), .st_irq(st_irq)
);

// File: tb/cmd_mailbox_bench.sv
module cmd_mailbox_bench;

    localparam logic [31:0] K1    = 32'h5F554E4C;
    localparam logic [31:0] K2    = 32'h4F434B5F;
    localparam logic [31:0] KC    = 32'hFFFFFFFF;
    localparam logic [31:0] IDENT = 32'h53437632;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        cmd_valid;
    logic [7:0]  cmd_id;
    logic [31:0] cmd_arg0, cmd_arg1;
    logic        ctl_done = 1'b0, ctl_err = 1'b0, ctl_irq = 1'b0;
    logic [31:0] ctl_data0 = '0, ctl_data1 = '0;
    logic        unlocked;

    always #2.5 clk = ~clk;

    cmd_mailbox u_cmd_mailbox (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .cmd_valid(cmd_valid),
        .cmd_id(cmd_id), .cmd_arg0(cmd_arg0), .cmd_arg1(cmd_arg1),
        .ctl_done(ctl_done), .ctl_err(ctl_err), .ctl_data0(ctl_data0),
        .ctl_data1(ctl_data1), .ctl_irq(ctl_irq), .unlocked(unlocked)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // bench model of the visible state
    bit        m_open = 0, m_half = 0, m_busy = 0, m_err = 0, m_irq = 0, m_cmdv = 0;
    bit [7:0]  m_id = 0;
    bit [31:0] m_d0 = 0, m_d1 = 0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mread(logic [2:0] a);
        if (!m_open) return 32'h0;
        case (a)
            3'd0: return {m_busy, m_err, m_irq, 21'h0, m_id};
            3'd1: return m_d0;
            3'd2: return m_d1;
            3'd3: return IDENT;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string rtag(logic [2:0] a);
        if (!m_open) return "R5";
        case (a)
            3'd0, 3'd1, 3'd2: return "R8";
            3'd3: return "R9";
            default: return "R11";
        endcase
    endfunction

    // one clock cycle: drive at negedge, check outputs, then step the model
    task automatic cyc(bit wr, logic [2:0] a, logic [31:0] d,
                       bit dn = 0, bit de = 0, logic [31:0] r0 = 0,
                       logic [31:0] r1 = 0, bit irq = 0);
        bit pre_open, wok;
        @(negedge clk);
        host_wr = wr; host_addr = a; host_wdata = d;
        ctl_done = dn; ctl_err = de; ctl_data0 = r0; ctl_data1 = r1; ctl_irq = irq;
        #1;
        chk(rtag(a), host_rdata, mread(a));
        chk("R6", {31'h0, cmd_valid}, {31'h0, m_cmdv});
        if (m_cmdv) begin
            chk("R6", {24'h0, cmd_id}, {24'h0, m_id});
            chk("R6", cmd_arg0, m_d0);
            chk("R6", cmd_arg1, m_d1);
        end
        chk(m_open ? "R4" : "R2", {31'h0, unlocked}, {31'h0, m_open});
        @(posedge clk);
        pre_open = m_open;
        wok = wr && pre_open;
        if (wr && a == 3'd4) begin
            if (d == K1) m_half = 1;
            else begin
                if (m_half && d == K2 && !m_open) m_open = 1;
                if (d == KC && m_open) m_open = 0;
                m_half = 0;
            end
        end
        m_cmdv = wok && a == 3'd0;
        if (wok) begin
            case (a)
                3'd0: begin m_busy = 1; m_err = 0; m_id = d[7:0]; end
                3'd1: m_d0 = d;
                3'd2: m_d1 = d;
                3'd3: m_irq = 0;
                default: ;
            endcase
        end
        if (dn) begin
            m_d0 = r0; m_d1 = r1;
            if (!m_cmdv) begin m_busy = 0; m_err = de; end
        end
        if (irq) m_irq = 1;
    endtask

    task automatic unlock();
        cyc(1, 3'd4, K1);
        cyc(1, 3'd4, K2);
    endtask

    initial begin
        #(5ns * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", {31'h0, unlocked}, 32'h0);
        chk("R1", {31'h0, cmd_valid}, 32'h0);
        // R5: locked reads zero, locked writes ignored
        cyc(0, 3'd3, 0);
        cyc(1, 3'd1, 32'hDEAD_BEEF);
        cyc(1, 3'd0, 32'h0000_0077);
        cyc(0, 3'd0, 0);
        // R3: zero between the magic words breaks the sequence
        cyc(1, 3'd4, K1); cyc(1, 3'd4, 32'h0); cyc(1, 3'd4, K2);
        chk("R3", {31'h0, unlocked}, 32'h0);
        // R3: a stray value breaks it too
        cyc(1, 3'd4, K1); cyc(1, 3'd4, 32'h1234_5678); cyc(1, 3'd4, K2);
        chk("R3", {31'h0, unlocked}, 32'h0);
        // R3: a non-key access between the words does not break it
        cyc(1, 3'd4, K1); cyc(1, 3'd1, 32'h5); cyc(1, 3'd4, K2);
        cyc(0, 3'd0, 0);
        chk("R3", {31'h0, unlocked}, 32'h1);
        // R1/R5: state after reset untouched by locked writes
        chk("R1", host_rdata, 32'h0);
        cyc(0, 3'd1, 0);
        chk("R5", host_rdata, 32'h0);
        cyc(0, 3'd3, 0);  // R9
        cyc(0, 3'd4, 0);  // R11
        // R6/R8: command dispatch, upper written bits masked
        cyc(1, 3'd1, 32'hA0A0_0001);
        cyc(1, 3'd2, 32'hB0B0_0002);
        cyc(1, 3'd0, 32'hFFFF_FFA5);
        cyc(0, 3'd0, 0);
        cyc(0, 3'd0, 0);
        // R7: completion with error
        cyc(0, 3'd0, 0, 1, 1, 32'h0000_000E, 32'h0);
        cyc(0, 3'd0, 0);
        chk("R7", host_rdata, 32'h4000_00A5);
        cyc(0, 3'd1, 0);
        // R7: completion colliding with a new command
        cyc(1, 3'd0, 32'h3C, 1, 1, 32'h11, 32'h22);
        cyc(0, 3'd0, 0);
        chk("R7", host_rdata, 32'h8000_003C);
        // R10: set, clear, and set winning over clear
        cyc(0, 3'd0, 0, 0, 0, 0, 0, 1);
        cyc(1, 3'd3, 32'h0);
        cyc(1, 3'd3, 32'h0, 0, 0, 0, 0, 1);
        cyc(0, 3'd0, 0);
        chk("R10", host_rdata & 32'h2000_0000, 32'h2000_0000);
        // R3: repeated first word then second still unlocks (already open here), R4 lock
        cyc(1, 3'd4, KC);
        cyc(0, 3'd0, 0);
        chk("R4", {31'h0, unlocked}, 32'h0);
        cyc(1, 3'd4, K2);
        cyc(0, 3'd0, 0);
        chk("R2", {31'h0, unlocked}, 32'h0);
        cyc(1, 3'd4, K1); cyc(1, 3'd4, K1); cyc(1, 3'd4, K2);
        cyc(0, 3'd0, 0);
        chk("R2", {31'h0, unlocked}, 32'h1);

        // constrained random traffic checked against the model
        for (int i = 0; i < 3000; i++) begin
            int sel;
            sel = int'($urandom % 16);
            case (sel)
                0, 1, 2, 3, 4, 5: cyc(0, 3'($urandom), 0);
                6, 7, 8:          cyc(1, 3'($urandom % 4), $urandom);
                9:                cyc(1, 3'd4, $urandom);
                10:               unlock();
                11:               if ($urandom % 4 == 0) cyc(1, 3'd4, KC); else cyc(0, 3'd0, 0);
                12, 13:           cyc(0, 3'($urandom), 0, 1, 1'($urandom), $urandom, $urandom);
                14:               cyc($urandom % 2 == 0, 3'd3, $urandom, 0, 0, 0, 0, 1);
                default:          cyc(1, 3'd0, $urandom, 1'($urandom), 1'($urandom),
                                      $urandom, $urandom, 1'($urandom));
            endcase
        end
        cyc(0, 3'd0, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule